// File: doc/BRIEF.md
# Clock-Stop SPI Master Serializer

This block is the master side of a synchronous serial link whose clock runs only while a word is moving. It sends one parallel word and receives one at the same time. A one-cycle start strobe loads the transmit word and latches the clock divider and the word length. The block then pulls its active-low frame select low and, after a lead-in, toggles the serial clock once per bit. It drives data out most significant bit first and collects the return line into a receive word.

The serial clock idles low. Its period is `2 × (1 + div)` module clock cycles. When the divider is even and nonzero, the low phase is shortened to `div` cycles and the high phase takes the remainder, so the clock can be asymmetric. After the last falling edge the data output enable drops at once. Frame select stays low for one more serial period and then returns high. In that same cycle a one-cycle done pulse marks the receive word as valid.

Top module: `spi_cs_master`

## Requirements
- R1: While reset is held and afterwards until a start, fs_n is 1, sclk is 0, dx_oe is 0, dx is 0, done is 0 and rx_word is 0.
- R2: With divider value D, a serial period is 2·(1+D) cycles. For D zero or odd, the high phase and the low phase are each D+1 cycles. For D even and nonzero, the low phase is D cycles and the high phase is D+2 cycles.
- R3: fs_n goes low in the cycle after the accepted start. sclk then stays low for one low-phase length before its first rise.
- R4: Bits leave on dx from bit n-1 down to bit 0. Each bit appears in the cycle sclk rises and holds until the next rise.
- R5: At each falling edge of sclk the block samples dr. The first sample becomes bit n-1 of rx_word and the last becomes bit 0. Bits above n-1 read 0.
- R6: dx_oe is 1 from the first rising edge until the last falling edge, where it drops. dx reads 0 whenever dx_oe is 0.
- R7: fs_n returns to 1 exactly one serial period after the last falling edge. done is 1 for that single cycle, and rx_word already holds the new word in that cycle.
- R8: A start that arrives while a frame is in progress is ignored. The divider, length and transmit word are latched when a start is accepted, and later changes do not affect the running frame.
- R9: A word length below 8 is treated as 8, and a length above 32 is treated as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | module clock (one base tick) |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | begin a frame when idle |
| tx_word | input | 32 | word to send, right-aligned |
| div_sel | input | 8 | serial clock divider value D |
| word_len | input | 6 | bits per frame (clamped 8..32) |
| rx_word | output | 32 | received word, right-aligned |
| done | output | 1 | one-cycle frame-complete pulse |
| sclk | output | 1 | serial clock, idles low |
| fs_n | output | 1 | active-low frame select |
| dx | output | 1 | serial data out |
| dx_oe | output | 1 | output enable for dx |
| dr | input | 1 | serial data in |

## Verification
Frames are run with divider values 0, 1, 2, 3 and 4. Zero and odd values give a symmetric clock, while 2 and 4 give the shortened low phase, so a wrong parity rule shows up as a shifted edge. Word lengths of 8, 12, 16 and 32, together with out-of-range values 4 and 63, separate correct bit counting and clamping from off-by-one frames. Starts raised mid-frame with altered settings, and a start held high across the done cycle, show whether the block locks out new work while busy and takes the next frame on the first idle edge.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LEAD = 3'd1,
    PH_HIGH = 3'd2,
    PH_LOW  = 3'd3,
    PH_TAIL = 3'd4
  } phase_t;

  function automatic logic [5:0] clamp_len(input logic [5:0] req,
                                           input int lo, input int hi);
    logic [5:0] r;
    if (int'(req) < lo)      r = 6'(lo);
    else if (int'(req) > hi) r = 6'(hi);
    else                     r = req;
    return r;
  endfunction
endpackage

// File: rtl/spi_cs_phase_calc.sv
module spi_cs_phase_calc #(
  parameter int DIV_W = 8,
  localparam int CW = DIV_W + 2
) (
  input  logic [DIV_W-1:0] div,
  output logic [CW-1:0]    low_m1,
  output logic [CW-1:0]    high_m1,
  output logic [CW-1:0]    per_m1
);
  logic [CW-1:0] d_ext;
  logic          sym;

  always_comb begin
    d_ext = CW'(div);
    sym   = (div == '0) || div[0];
    per_m1 = (d_ext << 1) + CW'(1);
    if (sym) begin
      low_m1  = d_ext;
      high_m1 = d_ext;
    end else begin
      low_m1  = d_ext - CW'(1);
      high_m1 = d_ext + CW'(1);
    end
  end
endmodule

// File: rtl/spi_cs_shifter.sv
module spi_cs_shifter #(
  parameter int MAX_BITS = 32,
  parameter int LEN_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [MAX_BITS-1:0] load_word,
  input  logic [LEN_W-1:0]    load_len,
  input  logic                fall,
  input  logic                finish,
  input  logic                dr,
  output logic                tx_msb,
  output logic [MAX_BITS-1:0] rx_out
);
  logic [MAX_BITS-1:0] tx_sh;
  logic [MAX_BITS-1:0] rx_sh;
  logic [LEN_W:0]      pad;

  assign pad    = (LEN_W+1)'(MAX_BITS) - {1'b0, load_len};
  assign tx_msb = tx_sh[MAX_BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh  <= '0;
      rx_sh  <= '0;
      rx_out <= '0;
    end else begin
      if (load) begin
        tx_sh <= load_word << pad;
        rx_sh <= '0;
      end else if (fall) begin
        tx_sh <= {tx_sh[MAX_BITS-2:0], 1'b0};
        rx_sh <= {rx_sh[MAX_BITS-2:0], dr};
      end
      if (finish) rx_out <= rx_sh;
    end
  end
endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
  import spi_cs_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int LEN_W = 6,
  localparam int CW = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic [CW-1:0]    low_m1_in,
  input  logic [CW-1:0]    high_m1_in,
  input  logic [CW-1:0]    per_m1_in,
  input  logic             tx_msb,
  output logic             load,
  output logic             fall,
  output logic             finish,
  output logic             sclk,
  output logic             fs_n,
  output logic             dx,
  output logic             dx_oe,
  output logic             done
);
  phase_t         ph;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  low_m1, high_m1, per_m1;
  logic [LEN_W-1:0] bits_left;
  logic           cnt_end;

  assign cnt_end = (cnt == '0);
  assign load    = (ph == PH_IDLE) && start;
  assign fall    = (ph == PH_HIGH) && cnt_end;
  assign finish  = (ph == PH_TAIL) && cnt_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      low_m1    <= '0;
      high_m1   <= '0;
      per_m1    <= '0;
      bits_left <= '0;
      sclk      <= 1'b0;
      fs_n      <= 1'b1;
      dx        <= 1'b0;
      dx_oe     <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start) begin
            ph        <= PH_LEAD;
            low_m1    <= low_m1_in;
            high_m1   <= high_m1_in;
            per_m1    <= per_m1_in;
            cnt       <= low_m1_in;
            bits_left <= len - LEN_W'(1);
            fs_n      <= 1'b0;
          end
        end
        PH_LEAD: begin
          if (cnt_end) begin
            ph    <= PH_HIGH;
            cnt   <= high_m1;
            sclk  <= 1'b1;
            dx_oe <= 1'b1;
            dx    <= tx_msb;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        PH_HIGH: begin
          if (cnt_end) begin
            sclk <= 1'b0;
            if (bits_left == '0) begin
              ph    <= PH_TAIL;
              cnt   <= per_m1;
              dx_oe <= 1'b0;
              dx    <= 1'b0;
            end else begin
              ph  <= PH_LOW;
              cnt <= low_m1;
            end
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        PH_LOW: begin
          if (cnt_end) begin
            ph        <= PH_HIGH;
            cnt       <= high_m1;
            sclk      <= 1'b1;
            dx        <= tx_msb;
            bits_left <= bits_left - LEN_W'(1);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        PH_TAIL: begin
          if (cnt_end) begin
            ph   <= PH_IDLE;
            fs_n <= 1'b1;
            done <= 1'b1;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
  import spi_cs_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int MIN_BITS = 8,
  parameter int DIV_W = 8,
  parameter int LEN_W = 6,
  localparam int CW = DIV_W + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [MAX_BITS-1:0] tx_word,
  input  logic [DIV_W-1:0]    div_sel,
  input  logic [LEN_W-1:0]    word_len,
  output logic [MAX_BITS-1:0] rx_word,
  output logic                done,
  output logic                sclk,
  output logic                fs_n,
  output logic                dx,
  output logic                dx_oe,
  input  logic                dr
);
  logic [CW-1:0]    low_m1, high_m1, per_m1;
  logic [LEN_W-1:0] len_c;
  logic             load, fall, finish, tx_msb;

  assign len_c = LEN_W'(clamp_len(6'(word_len), MIN_BITS, MAX_BITS));

  spi_cs_phase_calc #(.DIV_W(DIV_W)) u_calc (
    .div     (div_sel),
    .low_m1  (low_m1),
    .high_m1 (high_m1),
    .per_m1  (per_m1)
  );

  spi_cs_seq #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .len        (len_c),
    .low_m1_in  (low_m1),
    .high_m1_in (high_m1),
    .per_m1_in  (per_m1),
    .tx_msb     (tx_msb),
    .load       (load),
    .fall       (fall),
    .finish     (finish),
    .sclk       (sclk),
    .fs_n       (fs_n),
    .dx         (dx),
    .dx_oe      (dx_oe),
    .done       (done)
  );

  spi_cs_shifter #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_word (tx_word),
    .load_len  (len_c),
    .fall      (fall),
    .finish    (finish),
    .dr        (dr),
    .tx_msb    (tx_msb),
    .rx_out    (rx_word)
  );
endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk (
  input logic clk,
  input logic rst,
  input logic sclk,
  input logic fs_n,
  input logic dx,
  input logic dx_oe,
  input logic done
);
  AST_CLK_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    fs_n |-> !sclk); // R3
  AST_OE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    dx_oe |-> !fs_n); // R6
  AST_DX_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    !dx_oe |-> !dx); // R6
  AST_DX_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(dx)); // R4
  AST_DONE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    done |-> (fs_n && !$past(fs_n))); // R7
  AST_RISE_HAS_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(fs_n) |-> done); // R7
endmodule

bind spi_cs_master spi_cs_master_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .sclk  (sclk),
  .fs_n  (fs_n),
  .dx    (dx),
  .dx_oe (dx_oe),
  .done  (done)
);

// File: tb/spi_cs_master_test.sv
module spi_cs_master_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] tx_word = '0;
  logic [7:0]  div_sel = '0;
  logic [5:0]  word_len = 6'd8;
  logic        dr = 1'b0;
  logic [31:0] rx_word;
  logic        done, sclk, fs_n, dx, dx_oe;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit live    = 0;
  bit fin     = 0;

  always #5 clk = ~clk;

  spi_cs_master uut (
    .clk(clk), .rst(rst), .start(start), .tx_word(tx_word),
    .div_sel(div_sel), .word_len(word_len), .rx_word(rx_word),
    .done(done), .sclk(sclk), .fs_n(fs_n), .dx(dx), .dx_oe(dx_oe), .dr(dr)
  );

  // behavioural reference
  bit m_busy;
  int m_j, m_n, m_l, m_h, m_t;
  logic [31:0] m_tx, m_acc;
  logic e_sclk, e_fs, e_dx, e_oe, e_done;
  logic [31:0] e_rx;

  always @(posedge clk) begin
    int jf, k, b, r;
    cycles++;
    if (rst) begin
      m_busy = 0; e_sclk = 0; e_fs = 1; e_dx = 0; e_oe = 0; e_done = 0; e_rx = 0;
    end else begin
      e_done = 0;
      if (!m_busy) begin
        if (start) begin
          int d;
          d = int'(div_sel);
          m_busy = 1; m_j = 0;
          m_n = int'(word_len);
          if (m_n < 8) m_n = 8;
          if (m_n > 32) m_n = 32;
          m_t = 2 * (1 + d);
          m_l = (d == 0 || d % 2 == 1) ? m_t / 2 : d;
          m_h = m_t - m_l;
          m_tx = tx_word; m_acc = 0;
        end
      end else m_j++;
      if (m_busy) begin
        jf = m_l + (m_n - 1) * m_t + m_h;
        e_fs = 0;
        if (m_j < m_l) begin
          e_sclk = 0; e_oe = 0; e_dx = 0;
        end else if (m_j < jf) begin
          k = m_j - m_l; b = k / m_t; r = k % m_t;
          e_sclk = (r < m_h); e_oe = 1; e_dx = m_tx[m_n - 1 - b];
          if (r == m_h) m_acc = {m_acc[30:0], dr};
        end else if (m_j < jf + m_t) begin
          e_sclk = 0; e_oe = 0; e_dx = 0;
          if (m_j == jf) m_acc = {m_acc[30:0], dr};
        end else begin
          e_fs = 1; e_done = 1; e_rx = m_acc; m_busy = 0;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk("R2", "sclk", 32'(sclk), 32'(e_sclk));
      chk("R3 R7", "fs_n", 32'(fs_n), 32'(e_fs));
      chk("R4", "dx", 32'(dx), 32'(e_dx));
      chk("R6", "dx_oe", 32'(dx_oe), 32'(e_oe));
      chk("R7", "done", 32'(done), 32'(e_done));
      chk("R5", "rx_word", rx_word, e_rx);
    end
    dr <= 1'($urandom);
  end

  task automatic frame(input logic [7:0] d, input logic [5:0] n, input logic [31:0] w);
    @(negedge clk);
    div_sel = d; word_len = n; tx_word = w; start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "fs_n", 32'(fs_n), 32'd1);
    chk("R1", "sclk", 32'(sclk), 32'd0);
    chk("R1", "dx_oe", 32'(dx_oe), 32'd0);
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "rx_word", rx_word, 32'd0);
    rst = 0; live = 1;
    repeat (3) @(negedge clk);
    chk("R1", "idle fs_n", 32'(fs_n), 32'd1);
    // R2 R4 R5: parity variants and lengths
    frame(8'd0, 6'd8, 32'h0000_00A5);
    frame(8'd1, 6'd16, 32'h0000_C3F0);
    frame(8'd2, 6'd8, 32'h0000_005A);
    frame(8'd4, 6'd12, 32'h0000_0B71);
    frame(8'd3, 6'd32, 32'hDEAD_BEEF);
    // R9: clamping
    frame(8'd0, 6'd4, 32'hFFFF_FF3C);
    frame(8'd1, 6'd63, 32'h1234_5678);
    // R8: start and new settings during a frame are ignored
    @(negedge clk);
    div_sel = 8'd2; word_len = 6'd10; tx_word = 32'h0000_02CD; start = 1;
    @(negedge clk);
    start = 0;
    repeat (7) @(negedge clk);
    div_sel = 8'd5; word_len = 6'd20; tx_word = 32'hFFFF_FFFF; start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    // R8: start held high through done launches next frame on first idle edge
    div_sel = 8'd0; word_len = 6'd8; tx_word = 32'h0000_0033; start = 1;
    @(negedge clk);
    while (!done) @(negedge clk);
    tx_word = 32'h0000_00C6;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R1", "final idle fs_n", 32'(fs_n), 32'd1);
    fin = 1;
  end

  initial begin
    while (!fin && cycles < 100000) @(posedge clk);
    if (!fin) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule